// File: doc/BRIEF.md
# Pin-Change and External Interrupt Flag Unit

This unit sits beside an 8-bit processor core and turns pin activity into interrupt requests. It watches two 8-bit input ports, port A and port B, and one external interrupt pin. Activity on the ports is merged into one shared pin-change flag. Activity on the external pin sets a separate external-interrupt flag. The unit then asks the core for one of two vectors. Vector 1 serves the external pin and vector 2 serves pin changes.

Two group enables decide which port pins can set the shared flag. The upper group is port B bits 7..4, port A bits 7, 6 and 3. The lower group is port B bits 3..0. A per-pin alternate-function mask removes single pins from detection. The external pin has four sense modes: low level, any edge, falling edge and rising edge.

A byte-wide register port gives access to three registers. The flag register is at address 0. A mask register at address 1 only stores its bits. The enable register is at address 2.

Each flag is a two-state machine, `pcx_flag_fsm`:
- **FLG_IDLE**: the flag reads zero. The *set* transition moves it to FLG_PEND when an event arrives.
- **FLG_PEND**: the flag is pending. The *clear* transition returns it to FLG_IDLE on a write of one or an acknowledge. The *force* transition returns it to FLG_IDLE when the external pin is in low-level mode.

An event arriving in the same cycle as a clear keeps FLG_PEND.

Top module: `pcx_irq_unit`

## Requirements
- R1: The upper group is port B bits 7..4 and port A bits 7, 6 and 3. It is gated by enable register bit 5. The lower group is port B bits 3..0. It is gated by enable register bit 4. Port A bits 5, 4, 2, 1 and 0 never set the pin-change flag.
- R2: A rising or falling level change on a covered pin whose group enable is set makes the pin-change flag read as set at the third rising clock edge after the change. This delay comes from two synchronizer stages plus the flag register. A change while the group enable is clear leaves the flag clear, and enabling the group later does not set it.
- R3: While a pin's alternate-function mask bit is 1, changes on that pin never set the pin-change flag.
- R4: `irq_vector` is 1 for an external-interrupt request and 2 for a pin-change request. When both are requested it is 1. It is 0 when nothing is requested.
- R5: The external request needs the external flag, enable register bit 6 and `gie` all set. The pin-change request needs the pin-change flag, enable bit 5 or bit 4, and `gie` all set. `irq_req` is high exactly when one of these requests is active.
- R6: An acknowledge with `ack_vec` equal to 1 clears the external flag, and one with `ack_vec` equal to 2 clears the pin-change flag. Writing a 1 to a flag bit in the flag register clears that flag. Writing a 0 to it leaves the flag unchanged.
- R7: `sense_mode` selects the external pin behaviour: 01 any edge, 10 falling edge, 11 rising edge. A matching edge sets the external flag three rising edges after it occurs, whether or not enable bit 6 is set.
- R8: With `sense_mode` 00 (low level), the external flag reads zero. The external request is then active while the synchronized pin is low, enable bit 6 is set and `gie` is set. This request appears at the second rising edge after the pin falls.
- R9: In the flag register, bit 6 is the external flag and bit 5 is the pin-change flag. Bits 7 and 4..0 read zero.
- R10: The mask register at address 1 stores bits 6, 5, 2 and 1. The enable register at address 2 stores bits 6, 5 and 4. All other bits, and address 3, read zero. Every register resets to zero.
- R11: If a flag event and a clear (by write or by acknowledge) hit the same clock edge, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_a | input | 8 | Port A pin levels (asynchronous) |
| port_b | input | 8 | Port B pin levels (asynchronous) |
| alt_fn_a | input | 8 | Per-pin alternate-function mask for port A; 1 blocks the pin |
| alt_fn_b | input | 8 | Per-pin alternate-function mask for port B; 1 blocks the pin |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| sense_mode | input | 2 | External pin sense: 00 low, 01 any edge, 10 falling, 11 rising |
| gie | input | 1 | Global interrupt enable from the core |
| ack_valid | input | 1 | Core acknowledges an interrupt this cycle |
| ack_vec | input | 2 | Vector being acknowledged (1 or 2) |
| reg_addr | input | 2 | Register select: 0 flags, 1 mask, 2 enables |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vector | output | 2 | Requested vector: 1 external, 2 pin change, 0 none |

## Verification
The bench targets the irregular group map: it toggles uncovered port A pins and pins of a disabled group. A design with a shifted or mirrored group mask would then raise the shared flag. It aims a write-clear and an acknowledge at the exact edge where a synchronized change lands. A design that lets the clear win would lose the event. It switches the external pin into low-level mode while its flag is pending. A design that does not hide the flag would show bit 6, or would request from a stale flag instead of the live pin level. It also raises both flags together. A design with inverted priority would present vector 2 first.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_t;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_t;

    localparam logic [1:0] ADDR_FLAG = 2'd0;
    localparam logic [1:0] ADDR_MASK = 2'd1;
    localparam logic [1:0] ADDR_EN   = 2'd2;

    localparam int EXT_BIT  = 6;
    localparam int GRP1_BIT = 5;
    localparam int GRP0_BIT = 4;
    localparam int PCF_BIT  = 5;

    localparam logic [1:0] VEC_NONE = 2'd0;
    localparam logic [1:0] VEC_EXT  = 2'd1;
    localparam logic [1:0] VEC_PC   = 2'd2;

endpackage

// File: rtl/pcx_sync_detect.sv
module pcx_sync_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    output logic [W-1:0] level,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            level  <= '0;
            prev   <= '0;
        end else begin
            meta_q <= pin;
            level  <= meta_q;
            prev   <= level;
        end
    end
endmodule

// File: rtl/pcx_ext_sense.sv
module pcx_ext_sense
    import pcx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] mode,
    output logic       level,
    output logic       edge_evt
);
    logic prev;

    pcx_sync_detect #(.W(1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pin),
        .level (level),
        .prev  (prev)
    );

    always_comb begin
        unique case (sense_t'(mode))
            SENSE_LOW:  edge_evt = 1'b0;
            SENSE_ANY:  edge_evt = level ^ prev;
            SENSE_FALL: edge_evt = prev & ~level;
            SENSE_RISE: edge_evt = level & ~prev;
            default:    edge_evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcx_flag_fsm.sv
module pcx_flag_fsm
    import pcx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    input  logic force_clr,
    output logic flag
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (set_evt && !force_clr) state_d = FLG_PEND;
            FLG_PEND: if (force_clr || (clr && !set_evt)) state_d = FLG_IDLE;
            default:  state_d = FLG_IDLE;
        endcase
    end

    assign flag = (state_q == FLG_PEND);

    // R11
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt && !force_clr) |=> flag);

    // R6
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr || force_clr) && !set_evt) |=> !flag);
endmodule

// File: rtl/pcx_irq_unit.sv
module pcx_irq_unit
    import pcx_pkg::*;
#(
    parameter int          PORT_W     = 8,
    parameter logic [7:0]  GRP1_A     = 8'hC8,
    parameter logic [7:0]  GRP1_B     = 8'hF0,
    parameter logic [7:0]  GRP0_A     = 8'h00,
    parameter logic [7:0]  GRP0_B     = 8'h0F,
    parameter logic [7:0]  MASK_RW    = 8'h66,
    parameter logic [7:0]  EN_RW      = 8'h70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_a,
    input  logic [PORT_W-1:0] port_b,
    input  logic [PORT_W-1:0] alt_fn_a,
    input  logic [PORT_W-1:0] alt_fn_b,
    input  logic              ext_pin,
    input  logic [1:0]        sense_mode,
    input  logic              gie,
    input  logic              ack_valid,
    input  logic [1:0]        ack_vec,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq_req,
    output logic [1:0]        irq_vector
);
    localparam int PW = PORT_W;

    logic [PW-1:0] a_lvl, a_prev, b_lvl, b_prev;
    logic [PW-1:0] a_hit, b_hit;
    logic [7:0]    mask_q, en_q;
    logic          ext_lvl, ext_evt, ext_flag, pc_flag;
    logic          grp1_evt, grp0_evt, pc_evt;
    logic          level_mode, ext_req, pc_req;
    logic          flag_wr;

    pcx_sync_detect #(.W(PW)) u_sync_a (
        .clk (clk), .rst_n (rst_n), .pin (port_a), .level (a_lvl), .prev (a_prev)
    );
    pcx_sync_detect #(.W(PW)) u_sync_b (
        .clk (clk), .rst_n (rst_n), .pin (port_b), .level (b_lvl), .prev (b_prev)
    );

    assign a_hit = (a_lvl ^ a_prev) & ~alt_fn_a;
    assign b_hit = (b_lvl ^ b_prev) & ~alt_fn_b;

    assign grp1_evt = en_q[GRP1_BIT] &
                      (|(a_hit & GRP1_A[PW-1:0]) | |(b_hit & GRP1_B[PW-1:0]));
    assign grp0_evt = en_q[GRP0_BIT] &
                      (|(a_hit & GRP0_A[PW-1:0]) | |(b_hit & GRP0_B[PW-1:0]));
    assign pc_evt   = grp1_evt | grp0_evt;

    pcx_ext_sense u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_pin),
        .mode     (sense_mode),
        .level    (ext_lvl),
        .edge_evt (ext_evt)
    );

    assign level_mode = (sense_t'(sense_mode) == SENSE_LOW);
    assign flag_wr    = reg_wr && (reg_addr == ADDR_FLAG);

    pcx_flag_fsm u_pc_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_evt   (pc_evt),
        .clr       ((flag_wr && reg_wdata[PCF_BIT]) || (ack_valid && ack_vec == VEC_PC)),
        .force_clr (1'b0),
        .flag      (pc_flag)
    );

    pcx_flag_fsm u_ext_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_evt   (ext_evt),
        .clr       ((flag_wr && reg_wdata[EXT_BIT]) || (ack_valid && ack_vec == VEC_EXT)),
        .force_clr (level_mode),
        .flag      (ext_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            en_q   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_MASK) mask_q <= reg_wdata & MASK_RW;
            if (reg_addr == ADDR_EN)   en_q   <= reg_wdata & EN_RW;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_FLAG: begin
                reg_rdata[EXT_BIT] = ext_flag & ~level_mode;
                reg_rdata[PCF_BIT] = pc_flag;
            end
            ADDR_MASK: reg_rdata = mask_q;
            ADDR_EN:   reg_rdata = en_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign ext_req = gie & en_q[EXT_BIT] & (level_mode ? ~ext_lvl : ext_flag);
    assign pc_req  = gie & (en_q[GRP1_BIT] | en_q[GRP0_BIT]) & pc_flag;

    always_comb begin
        irq_vector = VEC_NONE;
        if (ext_req)     irq_vector = VEC_EXT;
        else if (pc_req) irq_vector = VEC_PC;
    end
    assign irq_req = ext_req | pc_req;

    // R5
    irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> gie);

    // R4
    vec_matches_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (irq_vector != VEC_NONE));

    // R8
    level_flag_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_mode |=> (!level_mode || !ext_flag));

    // R3
    blocked_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_hit == '0) && (b_hit == '0) && !pc_flag) |=> !pc_flag);
endmodule

// File: tb/pcx_irq_unit_bench.sv
module pcx_irq_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] port_a = '0, port_b = '0, alt_fn_a = '0, alt_fn_b = '0;
    logic       ext_pin = 1'b0;
    logic [1:0] sense_mode = 2'b11;
    logic       gie = 1'b0, ack_valid = 1'b0;
    logic [1:0] ack_vec = '0, reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_req;
    logic [1:0] irq_vector;

    int checks = 0;
    int failures = 0;

    pcx_irq_unit u_pcx_irq_unit (
        .clk (clk), .rst_n (rst_n), .port_a (port_a), .port_b (port_b),
        .alt_fn_a (alt_fn_a), .alt_fn_b (alt_fn_b), .ext_pin (ext_pin),
        .sense_mode (sense_mode), .gie (gie), .ack_valid (ack_valid),
        .ack_vec (ack_vec), .reg_addr (reg_addr), .reg_wr (reg_wr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .irq_req (irq_req),
        .irq_vector (irq_vector)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: pin histories as queues, newest first
    logic [7:0] qa[$], qb[$];
    logic       qe[$];
    logic [7:0] m_mask, m_en;
    bit         m_pcf, m_exf;

    always @(posedge clk) begin
        if (!rst_n) begin
            qa = '{8'h00, 8'h00, 8'h00};
            qb = '{8'h00, 8'h00, 8'h00};
            qe = '{1'b0, 1'b0, 1'b0};
            m_mask = 0; m_en = 0; m_pcf = 0; m_exf = 0;
        end else begin
            logic [7:0] ca, cb;
            bit up, lo, pev, eev, rise, fall, pclr, eclr;
            ca = (qa[1] ^ qa[2]) & ~alt_fn_a;
            cb = (qb[1] ^ qb[2]) & ~alt_fn_b;
            up = m_en[5] && (cb[7] || cb[6] || cb[5] || cb[4] || ca[7] || ca[6] || ca[3]);
            lo = m_en[4] && (cb[3] || cb[2] || cb[1] || cb[0]);
            pev = up || lo;
            rise = qe[1] && !qe[2];
            fall = !qe[1] && qe[2];
            case (sense_mode)
                2'b01: eev = rise || fall;
                2'b10: eev = fall;
                2'b11: eev = rise;
                default: eev = 0;
            endcase
            pclr = (reg_wr && reg_addr == 0 && reg_wdata[5]) || (ack_valid && ack_vec == 2);
            eclr = (reg_wr && reg_addr == 0 && reg_wdata[6]) || (ack_valid && ack_vec == 1);
            if (pev) m_pcf = 1; else if (pclr) m_pcf = 0;
            if (sense_mode == 0) m_exf = 0; else if (eev) m_exf = 1; else if (eclr) m_exf = 0;
            if (reg_wr && reg_addr == 1) m_mask = reg_wdata & 8'h66;
            if (reg_wr && reg_addr == 2) m_en = reg_wdata & 8'h70;
            qa.push_front(port_a); void'(qa.pop_back());
            qb.push_front(port_b); void'(qb.pop_back());
            qe.push_front(ext_pin); void'(qe.pop_back());
        end
    end

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0h expected=%0h at %0t", req, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (rst_n) begin
            logic [7:0] exp_rd;
            bit er, pr;
            int ev;
            case (reg_addr)
                2'd0: exp_rd = {1'b0, m_exf && sense_mode != 0, m_pcf, 5'b0};
                2'd1: exp_rd = m_mask;
                2'd2: exp_rd = m_en;
                default: exp_rd = 0;
            endcase
            er = gie && m_en[6] && (sense_mode == 0 ? !qe[1] : m_exf);
            pr = gie && (m_en[5] || m_en[4]) && m_pcf;
            ev = er ? 1 : (pr ? 2 : 0);
            check(reg_addr == 0 ? "R9" : "R10", reg_rdata, exp_rd);
            check("R5", irq_req, er || pr);
            check("R4", irq_vector, ev);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        step(1);
        reg_wr = 0;
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic ack(input logic [1:0] v);
        ack_valid = 1; ack_vec = v;
        step(1);
        ack_valid = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        // R10: reset values
        rd("R10", 0, 8'h00); rd("R10", 1, 8'h00); rd("R10", 2, 8'h00); rd("R10", 3, 8'h00);
        check("R5", irq_req, 0);
        // R10: writable bit sets
        wr(1, 8'hFF); rd("R10", 1, 8'h66); wr(1, 8'h00);
        wr(2, 8'hFF); rd("R10", 2, 8'h70); wr(2, 8'h20);
        // R2: rising change on upper group pin
        port_b[5] = 1; step(2); rd("R2", 0, 8'h00); step(1); rd("R2", 0, 8'h20);
        check("R5", irq_req, 0);
        gie = 1; #1; check("R4", irq_vector, 2);
        // R6: acknowledge clears
        ack(2); rd("R6", 0, 8'h00);
        // R2: falling change also sets
        port_b[5] = 0; step(3); rd("R2", 0, 8'h20);
        wr(0, 8'h00); rd("R6", 0, 8'h20);
        wr(0, 8'h20); rd("R6", 0, 8'h00);
        // R2: disabled group does not set, nor does enabling later
        port_b[1] = 1; step(3); rd("R2", 0, 8'h00);
        wr(2, 8'h30); step(2); rd("R2", 0, 8'h00);
        // R1: uncovered port A pins, then covered ones
        port_a[5] = 1; port_a[0] = 1; port_a[2] = 1; step(3); rd("R1", 0, 8'h00);
        port_a[3] = 1; step(3); rd("R1", 0, 8'h20); wr(0, 8'h20);
        port_b[1] = 0; step(3); rd("R1", 0, 8'h20); wr(0, 8'h20);
        // R3: alternate function blocks its pin
        alt_fn_b[6] = 1; port_b[6] = 1; step(3); rd("R3", 0, 8'h00);
        alt_fn_b[6] = 0; step(1); rd("R3", 0, 8'h00);
        // R11: event and write-clear on the same edge
        port_a[6] = 1; step(2);
        reg_addr = 0; reg_wdata = 8'h20; reg_wr = 1; step(1); reg_wr = 0;
        rd("R11", 0, 8'h20);
        // R11: event and acknowledge on the same edge
        port_a[7] = 1; step(2); ack(2); rd("R11", 0, 8'h20);
        wr(0, 8'h20);
        // R7: rising mode sets flag even with ext enable off
        sense_mode = 2'b11; ext_pin = 1; step(3); rd("R7", 0, 8'h40);
        check("R5", irq_req, 0);
        wr(2, 8'h70); #1; check("R4", irq_vector, 1);
        wr(0, 8'h40); rd("R6", 0, 8'h00);
        ext_pin = 0; step(3); rd("R7", 0, 8'h00);
        sense_mode = 2'b10; ext_pin = 1; step(3); rd("R7", 0, 8'h00);
        ext_pin = 0; step(3); rd("R7", 0, 8'h40);
        ack(1); rd("R6", 0, 8'h00);
        sense_mode = 2'b01; ext_pin = 1; step(3); rd("R7", 0, 8'h40); wr(0, 8'h40);
        ext_pin = 0; step(3); rd("R7", 0, 8'h40); wr(0, 8'h40);
        // R4: both flags pending, external first
        port_b[4] = 1; ext_pin = 1; step(3); rd("R9", 0, 8'h60);
        check("R4", irq_vector, 1);
        ack(1); #1; check("R4", irq_vector, 2);
        ack(2); #1; check("R4", irq_vector, 0);
        // R8: low-level mode
        ext_pin = 0; step(3); rd("R8", 0, 8'h40);
        sense_mode = 2'b00; #1; rd("R8", 0, 8'h00); check("R8", irq_vector, 1);
        step(1); sense_mode = 2'b01; #1; rd("R8", 0, 8'h00);
        sense_mode = 2'b00;
        gie = 0; #1; check("R8", irq_req, 0);
        gie = 1; ext_pin = 1; step(1); check("R8", irq_req, 1);
        step(1); check("R8", irq_req, 0);
        ext_pin = 0; step(2); check("R8", irq_vector, 1);
        step(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule